// File: doc/BRIEF.md
# Clock Page-Replacement Victim Selector

This block picks which physical frame gives up its page when a page fault occurs. It keeps one entry per frame: the tag of the page held there, a valid flag, a reference (r) bit, a modify (m) bit and a separate dirty flag. A circular pointer marks the frame to examine next. While the block is idle, reference and write events mark the frame that holds the matching page. A fault request starts a scan. The scan moves one frame per clock and clears bits as it passes. Frames that have recently been used are passed over once. When the third-chance mode is on, modified frames are passed over one more time.

When the scan finds a victim, the new page is loaded into that frame and the pointer moves past it. The block then raises a one-cycle done pulse. With the pulse it gives the frame index, the tag that was evicted, whether that frame held a page, and whether that page must be written back before the frame is reused. The m bit only controls how many chances a page gets. The dirty flag is set on every write and is cleared only when a new page is loaded, so a page whose m bit the scan has cleared still reports a write-back when it is evicted.

The controller has three states:
- `ST_IDLE` accepts events. A fault request moves it to `ST_SCAN` and latches the new tag, the access type and the mode.
- `ST_SCAN` examines one frame per cycle. It stays in `ST_SCAN` while it skips frames, and moves to `ST_REPORT` when it picks a victim.
- `ST_REPORT` drives done for one cycle and always returns to `ST_IDLE`.

Top module: `clock_evict`

## Requirements
- R1: After reset, every frame is empty and the pointer is at frame 0. busy and done are low, and the first fault takes frame 0 with evicted_valid = 0 and writeback = 0.
- R2: An empty frame is taken as soon as the scan reaches it. Starting from reset, successive faults fill frames 0, 1, 2, 3 in order, each after examining a single frame.
- R3: A reference (ref_valid with ref_write = 0) to a resident page sets that frame's r bit and does not move the pointer.
- R4: A write event (ref_valid with ref_write = 1) to a resident page sets its r bit, its m bit and its dirty flag.
- R5: During a scan, a frame with r = 1 has r cleared and is skipped, and the pointer advances by one.
- R6: In third-chance mode (third_en = 1), a frame with r = 0 and m = 1 has m cleared and is skipped.
- R7: The scan picks the first frame it examines whose r and m bits are both 0 (or that is empty). victim_idx reports that frame, and the pointer then moves to the next frame, wrapping from NUM_FRAMES-1 to 0.
- R8: When no frame is picked on a full sweep, the scan continues. A scan examines at most 2*NUM_FRAMES+1 frames, and the number of cycles from accept to done equals the number of frames examined.
- R9: writeback equals the evicted frame's dirty flag, which stays set even after the scan clears m. evicted_tag reports the tag that was displaced.
- R10: A newly loaded page starts with r = 1. Its m bit and dirty flag equal fault_write.
- R11: In second-chance mode (third_en = 0), a frame with r = 0 is picked whatever its m bit, and still reports writeback when it is dirty.
- R12: A fault is accepted only when busy is low. busy is high from the cycle after accept through the done cycle, and done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Access event for a resident page, applied only while idle |
| ref_tag | input | TAG_W | Page tag of the access event |
| ref_write | input | 1 | Access event is a write |
| fault_req | input | 1 | Request to select a victim for a missing page |
| fault_tag | input | TAG_W | Tag of the page to load |
| fault_write | input | 1 | The faulting access is a write |
| third_en | input | 1 | 1: modified pages get an extra pass; 0: plain second chance |
| busy | output | 1 | Scan or report in progress |
| done | output | 1 | One-cycle pulse: victim result valid |
| victim_idx | output | IDX_W | Frame that received the new page |
| writeback | output | 1 | Evicted page is dirty and must be saved |
| evicted_tag | output | TAG_W | Tag that was displaced |
| evicted_valid | output | 1 | The chosen frame held a page |

## Verification
The bench builds the block with four frames and 8-bit tags. With that size, a full three-pass sweep of nine examinations fits in a short vector list, and the pointer wraps several times. Four frames are also enough to mix clean, dirty, referenced and empty frames in one scan. As a result, each skip rule and each mode can be seen through the victim index, the evicted tag, the write-back flag and the cycle count.

// File: rtl/clock_evict_pkg.sv
package clock_evict_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_REPORT
    } scan_state_e;

    typedef struct packed {
        logic valid;
        logic r;
        logic m;
        logic dirty;
    } frame_flags_t;

endpackage

// File: rtl/clock_evict_frames.sv
module clock_evict_frames
    import clock_evict_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter int TAG_W      = 8,
    localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_en,
    input  logic [TAG_W-1:0]   evt_tag,
    input  logic               evt_write,
    input  logic [IDX_W-1:0]   sel_idx,
    input  logic               clr_r,
    input  logic               clr_m,
    input  logic               load_en,
    input  logic [TAG_W-1:0]   load_tag,
    input  logic               load_write,
    output frame_flags_t       sel_flags,
    output logic [TAG_W-1:0]   sel_tag
);

    logic [TAG_W-1:0]      tag_q [NUM_FRAMES];
    frame_flags_t          flg_q [NUM_FRAMES];
    logic [NUM_FRAMES-1:0] hit_vec;

    // One tag comparator per frame.
    generate
        for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_match
            assign hit_vec[g] = flg_q[g].valid && (tag_q[g] == evt_tag);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_FRAMES; i++) begin
                tag_q[i] <= '0;
                flg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_FRAMES; i++) begin
                if (load_en && (sel_idx == IDX_W'(i))) begin
                    tag_q[i]       <= load_tag;
                    flg_q[i].valid <= 1'b1;
                    flg_q[i].r     <= 1'b1;
                    flg_q[i].m     <= load_write;
                    flg_q[i].dirty <= load_write;
                end else if (clr_r && (sel_idx == IDX_W'(i))) begin
                    flg_q[i].r <= 1'b0;
                end else if (clr_m && (sel_idx == IDX_W'(i))) begin
                    flg_q[i].m <= 1'b0;
                end else if (evt_en && hit_vec[i]) begin
                    flg_q[i].r <= 1'b1;
                    if (evt_write) begin
                        flg_q[i].m     <= 1'b1;
                        flg_q[i].dirty <= 1'b1;
                    end
                end
            end
        end
    end

    assign sel_flags = flg_q[sel_idx];
    assign sel_tag   = tag_q[sel_idx];

endmodule

// File: rtl/clock_evict_ptr.sv
module clock_evict_ptr #(
    parameter int NUM_FRAMES = 4,
    localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/clock_evict_fsm.sv
module clock_evict_fsm
    import clock_evict_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter int TAG_W      = 8,
    localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic             fault_req,
    input  logic [TAG_W-1:0] fault_tag,
    input  logic             fault_write,
    input  logic             third_en,
    input  frame_flags_t     sel_flags,
    input  logic [TAG_W-1:0] sel_tag,
    input  logic [IDX_W-1:0] sel_idx,
    output logic             evt_en,
    output logic             step,
    output logic             clr_r,
    output logic             clr_m,
    output logic             load_en,
    output logic [TAG_W-1:0] load_tag,
    output logic             load_write,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] victim_idx,
    output logic             writeback,
    output logic [TAG_W-1:0] evicted_tag,
    output logic             evicted_valid
);

    scan_state_e state_q, state_d;
    logic        mode_q;
    logic        pick;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign pick = !sel_flags.valid ||
                  (!sel_flags.r && (!sel_flags.m || !mode_q));

    // Next state and per-frame scan actions.
    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        clr_r   = 1'b0;
        clr_m   = 1'b0;
        load_en = 1'b0;
        evt_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                evt_en = ref_valid;
                if (fault_req) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                step = 1'b1;
                if (pick) begin
                    load_en = 1'b1;
                    state_d = ST_REPORT;
                end else if (sel_flags.r) begin
                    clr_r = 1'b1;
                end else begin
                    clr_m = 1'b1;
                end
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_tag      <= '0;
            load_write    <= 1'b0;
            mode_q        <= 1'b0;
            victim_idx    <= '0;
            writeback     <= 1'b0;
            evicted_tag   <= '0;
            evicted_valid <= 1'b0;
        end else begin
            if ((state_q == ST_IDLE) && fault_req) begin
                load_tag   <= fault_tag;
                load_write <= fault_write;
                mode_q     <= third_en;
            end
            if (load_en) begin
                victim_idx    <= sel_idx;
                writeback     <= sel_flags.valid && sel_flags.dirty;
                evicted_tag   <= sel_tag;
                evicted_valid <= sel_flags.valid;
            end
        end
    end

    // Outputs.
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_REPORT);
    end

endmodule

// File: rtl/clock_evict.sv
module clock_evict
    import clock_evict_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter int TAG_W      = 8,
    localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic [TAG_W-1:0] ref_tag,
    input  logic             ref_write,
    input  logic             fault_req,
    input  logic [TAG_W-1:0] fault_tag,
    input  logic             fault_write,
    input  logic             third_en,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] victim_idx,
    output logic             writeback,
    output logic [TAG_W-1:0] evicted_tag,
    output logic             evicted_valid
);

    logic             evt_en, step, clr_r, clr_m, load_en, load_write;
    logic [TAG_W-1:0] load_tag, sel_tag;
    logic [IDX_W-1:0] ptr_q;
    frame_flags_t     sel_flags;

    clock_evict_ptr #(.NUM_FRAMES(NUM_FRAMES)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .ptr   (ptr_q)
    );

    clock_evict_frames #(.NUM_FRAMES(NUM_FRAMES), .TAG_W(TAG_W)) u_frames (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_en     (evt_en),
        .evt_tag    (ref_tag),
        .evt_write  (ref_write),
        .sel_idx    (ptr_q),
        .clr_r      (clr_r),
        .clr_m      (clr_m),
        .load_en    (load_en),
        .load_tag   (load_tag),
        .load_write (load_write),
        .sel_flags  (sel_flags),
        .sel_tag    (sel_tag)
    );

    clock_evict_fsm #(.NUM_FRAMES(NUM_FRAMES), .TAG_W(TAG_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_valid     (ref_valid),
        .fault_req     (fault_req),
        .fault_tag     (fault_tag),
        .fault_write   (fault_write),
        .third_en      (third_en),
        .sel_flags     (sel_flags),
        .sel_tag       (sel_tag),
        .sel_idx       (ptr_q),
        .evt_en        (evt_en),
        .step          (step),
        .clr_r         (clr_r),
        .clr_m         (clr_m),
        .load_en       (load_en),
        .load_tag      (load_tag),
        .load_write    (load_write),
        .busy          (busy),
        .done          (done),
        .victim_idx    (victim_idx),
        .writeback     (writeback),
        .evicted_tag   (evicted_tag),
        .evicted_valid (evicted_valid)
    );

endmodule

// File: rtl/clock_evict_checker.sv
module clock_evict_checker #(
    parameter int NUM_FRAMES = 4,
    localparam int IDX_W     = $clog2(NUM_FRAMES),
    localparam int MAX_EXAM  = 2 * NUM_FRAMES + 1,
    localparam int CW        = $clog2(MAX_EXAM + 4) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fault_req,
    input logic             busy,
    input logic             done,
    input logic [IDX_W-1:0] victim_idx,
    input logic             writeback,
    input logic             evicted_valid,
    input logic [IDX_W-1:0] ptr
);

    logic [CW-1:0]    busy_cnt;
    logic [IDX_W-1:0] exp_ptr;

    always_ff @(posedge clk) begin
        if (!rst_n)                busy_cnt <= '0;
        else if (!busy)            busy_cnt <= '0;
        else if (busy_cnt != '1)   busy_cnt <= busy_cnt + 1'b1;
    end

    always_comb begin
        exp_ptr = (victim_idx == IDX_W'(NUM_FRAMES - 1)) ? '0 : victim_idx + 1'b1;
    end

    // R12: done lasts one cycle
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: a fault taken while idle makes the block busy
    a_r12_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_req && !busy) |=> busy);

    // R12: done only appears inside a busy window
    a_r12_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R8: scan length bounded by three sweeps
    a_r8_scan_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt <= CW'(MAX_EXAM)));

    // R7: pointer sits just past the victim when done is reported
    a_r7_ptr_past_victim: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ptr == exp_ptr));

    // R9: an empty frame never needs a write-back
    a_r9_empty_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !evicted_valid) |-> !writeback);

endmodule

bind clock_evict clock_evict_checker #(.NUM_FRAMES(NUM_FRAMES)) u_clock_evict_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .fault_req     (fault_req),
    .busy          (busy),
    .done          (done),
    .victim_idx    (victim_idx),
    .writeback     (writeback),
    .evicted_valid (evicted_valid),
    .ptr           (ptr_q)
);

// File: tb/clock_evict_bench.sv
module clock_evict_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NF         = 4;
    localparam int TW         = 8;
    localparam int NV         = 21;

    // Vector: {op[30:29], tag[28:21], third[20], idx[19:18], wb[17], evv[16], evtag[15:8], exams[7:0]}
    // op: 0 reference, 1 write event, 2 read fault, 3 write fault
    localparam logic [30:0] VEC [NV] = '{
        {2'd2, 8'hA0, 1'b1, 2'd0, 1'b0, 1'b0, 8'h00, 8'd1},
        {2'd3, 8'hA1, 1'b1, 2'd1, 1'b0, 1'b0, 8'h00, 8'd1},
        {2'd2, 8'hA2, 1'b1, 2'd2, 1'b0, 1'b0, 8'h00, 8'd1},
        {2'd2, 8'hA3, 1'b1, 2'd3, 1'b0, 1'b0, 8'h00, 8'd1},
        {2'd2, 8'hB0, 1'b1, 2'd0, 1'b0, 1'b1, 8'hA0, 8'd5},
        {2'd2, 8'hB1, 1'b1, 2'd2, 1'b0, 1'b1, 8'hA2, 8'd2},
        {2'd0, 8'hA3, 1'b1, 2'd0, 1'b0, 1'b0, 8'h00, 8'd0},
        {2'd1, 8'hB0, 1'b1, 2'd0, 1'b0, 1'b0, 8'h00, 8'd0},
        {2'd2, 8'hB2, 1'b1, 2'd1, 1'b1, 1'b1, 8'hA1, 8'd3},
        {2'd2, 8'hB3, 1'b0, 2'd3, 1'b0, 1'b1, 8'hA3, 8'd2},
        {2'd2, 8'hC0, 1'b0, 2'd0, 1'b1, 1'b1, 8'hB0, 8'd1},
        {2'd1, 8'hB2, 1'b1, 2'd0, 1'b0, 1'b0, 8'h00, 8'd0},
        {2'd1, 8'hB1, 1'b1, 2'd0, 1'b0, 1'b0, 8'h00, 8'd0},
        {2'd1, 8'hB3, 1'b1, 2'd0, 1'b0, 1'b0, 8'h00, 8'd0},
        {2'd1, 8'hC0, 1'b1, 2'd0, 1'b0, 1'b0, 8'h00, 8'd0},
        {2'd2, 8'hC1, 1'b1, 2'd1, 1'b1, 1'b1, 8'hB2, 8'd9},
        {2'd3, 8'hC2, 1'b1, 2'd2, 1'b1, 1'b1, 8'hB1, 8'd1},
        {2'd2, 8'hC3, 1'b1, 2'd3, 1'b1, 1'b1, 8'hB3, 8'd1},
        {2'd2, 8'hD0, 1'b1, 2'd0, 1'b1, 1'b1, 8'hC0, 8'd1},
        {2'd2, 8'hD1, 1'b1, 2'd1, 1'b0, 1'b1, 8'hC1, 8'd5},
        {2'd2, 8'hD2, 1'b1, 2'd3, 1'b0, 1'b1, 8'hC3, 8'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic [TW-1:0] ref_tag = '0;
    logic          ref_write = 1'b0;
    logic          fault_req = 1'b0;
    logic [TW-1:0] fault_tag = '0;
    logic          fault_write = 1'b0;
    logic          third_en = 1'b0;
    logic          busy, done, writeback, evicted_valid;
    logic [1:0]    victim_idx;
    logic [TW-1:0] evicted_tag;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    clock_evict #(.NUM_FRAMES(NF), .TAG_W(TW)) u_clock_evict (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_valid     (ref_valid),
        .ref_tag       (ref_tag),
        .ref_write     (ref_write),
        .fault_req     (fault_req),
        .fault_tag     (fault_tag),
        .fault_write   (fault_write),
        .third_en      (third_en),
        .busy          (busy),
        .done          (done),
        .victim_idx    (victim_idx),
        .writeback     (writeback),
        .evicted_tag   (evicted_tag),
        .evicted_valid (evicted_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string vec_req(input int i);
        case (i)
            0, 1, 2, 3: return "R2 fill order";
            4:          return "R5 r cleared and skipped";
            5:          return "R6 m chance";
            8:          return "R3 R4 pointer kept, write marks";
            9, 10:      return "R11 second-chance mode";
            15:         return "R8 three sweeps";
            19, 20:     return "R10 loaded page bits";
            default:    return "R7 victim index";
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_event(input logic [TW-1:0] tag, input logic wr);
        @(negedge clk);
        ref_valid = 1'b1;
        ref_tag   = tag;
        ref_write = wr;
        @(negedge clk);
        ref_valid = 1'b0;
        ref_write = 1'b0;
    endtask

    task automatic do_fault(input logic [TW-1:0] tag, input logic wr, input logic mode,
                            input string req, input int exp_idx, input logic exp_wb,
                            input logic exp_evv, input logic [TW-1:0] exp_tag, input int exp_n);
        int n;
        @(negedge clk);
        fault_req   = 1'b1;
        fault_tag   = tag;
        fault_write = wr;
        third_en    = mode;
        @(negedge clk);
        fault_req   = 1'b0;
        chk("R12 busy after accept", 32'(busy), 32'd1);
        n = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk({req, " index"}, 32'(victim_idx), 32'(exp_idx));
        chk("R9 writeback", 32'(writeback), 32'(exp_wb));
        chk("R9 evicted tag", 32'(evicted_tag), 32'(exp_tag));
        chk("R2 evicted valid", 32'(evicted_valid), 32'(exp_evv));
        chk("R8 examined frames", 32'(n), 32'(exp_n));
        @(negedge clk);
        chk("R12 done one cycle", 32'(done), 32'd0);
        chk("R12 idle after done", 32'(busy), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 busy after reset", 32'(busy), 32'd0);
        chk("R1 done after reset", 32'(done), 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            op = VEC[i][30:29];
            if (op[1]) begin
                do_fault(VEC[i][28:21], op[0], VEC[i][20], vec_req(i),
                         int'(VEC[i][19:18]), VEC[i][17], VEC[i][16],
                         VEC[i][15:8], int'(VEC[i][7:0]));
            end else begin
                do_event(VEC[i][28:21], op[0]);
            end
        end

        // R1: reset mid-life restores empty frames and pointer 0
        do_reset();
        chk("R1 busy after second reset", 32'(busy), 32'd0);
        do_fault(8'h77, 1'b0, 1'b1, "R1 first fault after reset",
                 0, 1'b0, 1'b0, 8'h00, 1);

        // R4 R9: write to the loaded page makes its eviction dirty; R7 wrap via fill
        do_event(8'h77, 1'b1);
        do_fault(8'h78, 1'b0, 1'b1, "R7 next empty", 1, 1'b0, 1'b0, 8'h00, 1);
        do_fault(8'h79, 1'b0, 1'b1, "R7 next empty", 2, 1'b0, 1'b0, 8'h00, 1);
        do_fault(8'h7A, 1'b0, 1'b1, "R7 last frame", 3, 1'b0, 1'b0, 8'h00, 1);
        // all r = 1, frame 0 also m = 1: sweep clears r, then m of 0, then takes frame 1
        do_fault(8'h7B, 1'b0, 1'b1, "R6 dirty frame skipped", 1, 1'b0, 1'b1, 8'h78, 6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule